// File: doc/BRIEF.md
# Floating-Point Multiplier

This block multiplies two packed binary floating-point words of a parameterized format: one sign bit, an `EXP_W`-bit biased exponent and a `FRAC_W`-bit stored fraction, bias `2^(EXP_W-1)-1`. It returns the packed product together with four flags: invalid, overflow, underflow and inexact. A caller presents both operands with a one-cycle `start_i` pulse while the unit is idle. It then waits for the one-cycle `done_o` pulse and reads the result, which stays unchanged until the next accepted start. Only round-to-nearest-even is implemented.

The work is sequenced by a small state machine with six states:
- `ST_IDLE` waits for a start.
- `ST_CLASSIFY` sorts the captured operands into zero, finite, infinity or NaN and adds the two biased exponents less one bias. If either operand is special it writes the final answer and goes straight to `ST_DONE`. Otherwise it launches the significand multiply and goes to `ST_MULTIPLY`.
- `ST_MULTIPLY` runs an iterative shift-add multiply of the two `FRAC_W+1`-bit significands. The implicit bit is 1 for normal inputs and 0 for denormals. When the full double-width product is ready it moves to `ST_NORMALIZE`.
- `ST_NORMALIZE` adjusts the product one bit per cycle. It shifts right (collecting sticky) when the product is at or above 2 or the exponent is below 1, and shifts left when the leading bit is missing and the exponent is above 1. When neither applies it moves to `ST_ROUND`.
- `ST_ROUND` rounds away the low half, renormalizes on a carry, detects overflow and tiny results, writes the output and moves to `ST_DONE`.
- `ST_DONE` lasts one cycle and returns to `ST_IDLE`.

Top module: `fp_mult_unit`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it, `busy_o`, `done_o`, `result_o` and all four flags are zero.
- R2: A `start_i` seen in the idle state is accepted. `busy_o` is high from the next cycle until `done_o` has pulsed for exactly one cycle, then it drops. A `start_i` raised while busy is ignored and leaves the operation in flight unaffected.
- R3: For every non-NaN result, the sign bit (word bit `EXP_W+FRAC_W`) is the XOR of the operand signs.
- R4: For finite nonzero operands the result exponent is the sum of the biased exponents minus one bias. A significand product at or above 2 is shifted right one bit and the exponent is raised by one.
- R5: Dropped product bits are rounded to nearest with ties to even, using the first dropped bit as guard and the OR of the rest as sticky. `inexact_o` is set whenever any dropped bit is nonzero.
- R6: When rounding carries out of the significand, the significand becomes 1.0 and the exponent is raised by one. This can itself lead to overflow.
- R7: If the final biased exponent reaches the all-ones code, the result is an infinity with the product sign, and `overflow_o` and `inexact_o` are set. The largest finite magnitude times one does not overflow.
- R8: A denormal operand (exponent field 0, fraction nonzero) is read with implicit bit 0 and exponent 1. Its product is left-normalized when the exponent allows.
- R9: A result below the smallest normal is delivered as a denormal or zero with exponent field 0. `underflow_o` is set only when the rounded result is tiny and inexact. A product that rounds up to the smallest normal is not tiny.
- R10: A NaN operand (exponent all ones, fraction nonzero) gives the canonical NaN: sign 0, exponent all ones, fraction MSB 1 and the other fraction bits 0. No flag is raised.
- R11: Infinity times zero gives the canonical NaN with `invalid_o` set. Infinity times any nonzero non-NaN value gives an infinity with the product sign and no flags.
- R12: Zero times any finite value gives a zero with the product sign and no flags.
- R13: The result and flags stay stable from the `done_o` pulse until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a multiply with the present operands (idle only) |
| op_a_i | input | EXP_W+FRAC_W+1 | First packed operand |
| op_b_i | input | EXP_W+FRAC_W+1 | Second packed operand |
| busy_o | output | 1 | High while an operation is in progress, including the done cycle |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| result_o | output | EXP_W+FRAC_W+1 | Packed product |
| invalid_o | output | 1 | Infinity multiplied by zero |
| overflow_o | output | 1 | Result too large, infinity returned |
| underflow_o | output | 1 | Tiny and inexact result |
| inexact_o | output | 1 | Some precision was lost |

## Verification
The bench builds the unit with `EXP_W=3` and `FRAC_W=3`, a 7-bit word with bias 3, largest finite value 15 and smallest denormal 1/32. With such a narrow format, every rounding corner can be reached with operands whose products can be worked out by hand: exact ties going both ways, a rounding carry that crosses into a new binade or into infinity, denormal results that round to zero or up to the smallest normal, and denormal operands that need several left shifts. The default single-width parameters are only elaborated. With them, the same cases need wide operands and long denormalization runs.

// File: rtl/fp_mult_pkg.sv
package fp_mult_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CLASSIFY  = 3'd1,
        ST_MULTIPLY  = 3'd2,
        ST_NORMALIZE = 3'd3,
        ST_ROUND     = 3'd4,
        ST_DONE      = 3'd5
    } fpm_state_e;

    typedef enum logic [1:0] {
        CL_ZERO   = 2'd0,
        CL_FINITE = 2'd1,
        CL_INF    = 2'd2,
        CL_NAN    = 2'd3
    } fpm_class_e;

endpackage

// File: rtl/fp_mult_unpack.sv
module fp_mult_unpack
    import fp_mult_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word_i,
    output logic                  sign_o,
    output fpm_class_e            class_o,
    output logic [FRAC_W:0]       sig_o,
    output logic [EXP_W-1:0]      exp_o
);

    logic [EXP_W-1:0]  exp_field;
    logic [FRAC_W-1:0] frac_field;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_zero;

    always_comb begin
        exp_field  = word_i[FRAC_W +: EXP_W];
        frac_field = word_i[FRAC_W-1:0];
        exp_ones   = &exp_field;
        exp_zero   = ~|exp_field;
        frac_zero  = ~|frac_field;
        sign_o     = word_i[EXP_W+FRAC_W];

        if (exp_ones)
            class_o = frac_zero ? CL_INF : CL_NAN;
        else if (exp_zero && frac_zero)
            class_o = CL_ZERO;
        else
            class_o = CL_FINITE;

        // denormal: hidden bit 0, exponent read as 1
        sig_o = {~exp_zero, frac_field};
        exp_o = exp_zero ? EXP_W'(1) : exp_field;
    end

endmodule

// File: rtl/fp_mult_sigmul.sv
module fp_mult_sigmul #(
    parameter int SIG_W = 24,
    localparam int PROD_W = 2 * SIG_W,
    localparam int CNT_W  = $clog2(SIG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SIG_W-1:0]  mcand_i,
    input  logic [SIG_W-1:0]  mplier_i,
    output logic              busy_o,
    output logic [PROD_W-1:0] prod_o
);

    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(SIG_W - 1);

    logic [PROD_W-1:0] acc_q;
    logic [PROD_W-1:0] mcand_q;
    logic [SIG_W-1:0]  mplier_q;
    logic [CNT_W-1:0]  step_q;
    logic              busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            step_q   <= '0;
            busy_q   <= 1'b0;
        end else if (start_i) begin
            acc_q    <= '0;
            mcand_q  <= {{SIG_W{1'b0}}, mcand_i};
            mplier_q <= mplier_i;
            step_q   <= '0;
            busy_q   <= 1'b1;
        end else if (busy_q) begin
            if (mplier_q[0])
                acc_q <= acc_q + mcand_q;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
            step_q   <= step_q + CNT_W'(1);
            if (step_q == LAST_STEP)
                busy_q <= 1'b0;
        end
    end

    assign busy_o = busy_q;
    assign prod_o = acc_q;

endmodule

// File: rtl/fp_mult_round.sv
module fp_mult_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int XP_W   = 14,
    localparam int PROD_W = 2 * FRAC_W + 2,
    localparam int SUM_W  = FRAC_W + 2
) (
    input  logic                    sign_i,
    input  logic signed [XP_W-1:0]  exp_i,
    input  logic [PROD_W-1:0]       mag_i,
    input  logic                    sticky_i,
    output logic [EXP_W+FRAC_W:0]   word_o,
    output logic                    ovf_o,
    output logic                    unf_o,
    output logic                    inx_o
);

    localparam logic signed [XP_W-1:0] EXP_TOP = XP_W'((1 << EXP_W) - 1);

    logic [FRAC_W:0]        kept;
    logic                   guard;
    logic                   rest;
    logic                   round_up;
    logic [SUM_W-1:0]       sum;
    logic                   carry;
    logic [FRAC_W:0]        sig;
    logic signed [XP_W-1:0] exp_r;
    logic                   lost;
    logic [EXP_W-1:0]       exp_field;

    always_comb begin
        kept     = mag_i[2*FRAC_W -: FRAC_W+1];
        guard    = mag_i[FRAC_W-1];
        rest     = (|mag_i[FRAC_W-2:0]) | sticky_i;
        round_up = guard & (rest | kept[0]);
        sum      = {1'b0, kept} + SUM_W'(round_up);
        carry    = sum[FRAC_W+1];
        sig      = carry ? sum[FRAC_W+1:1] : sum[FRAC_W:0];
        exp_r    = carry ? exp_i + XP_W'(1) : exp_i;
        lost     = guard | rest;
        exp_field = sig[FRAC_W] ? exp_r[EXP_W-1:0] : '0;

        if (exp_r >= EXP_TOP) begin
            word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf_o  = 1'b1;
            unf_o  = 1'b0;
            inx_o  = 1'b1;
        end else begin
            word_o = {sign_i, exp_field, sig[FRAC_W-1:0]};
            ovf_o  = 1'b0;
            unf_o  = ~sig[FRAC_W] & lost;
            inx_o  = lost;
        end
    end

endmodule

// File: rtl/fp_mult_unit.sv
module fp_mult_unit
    import fp_mult_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [EXP_W+FRAC_W:0] op_a_i,
    input  logic [EXP_W+FRAC_W:0] op_b_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [EXP_W+FRAC_W:0] result_o,
    output logic                  invalid_o,
    output logic                  overflow_o,
    output logic                  underflow_o,
    output logic                  inexact_o
);

    localparam int WORD_W = EXP_W + FRAC_W + 1;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XP_W   = EXP_W + $clog2(PROD_W) + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [XP_W-1:0] EXP_ONE = XP_W'(1);
    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    fpm_state_e state_q, state_d;

    logic [WORD_W-1:0]      op_a_q, op_b_q;
    logic                   sign_a, sign_b;
    fpm_class_e             cls_a, cls_b;
    logic [SIG_W-1:0]       sig_a, sig_b;
    logic [EXP_W-1:0]       exp_a, exp_b;

    logic [PROD_W-1:0]      prod_q;
    logic signed [XP_W-1:0] exp_q;
    logic                   sticky_q;
    logic                   sign_q;
    logic [WORD_W-1:0]      result_q;
    logic [3:0]             flags_q;

    logic                   mul_start;
    logic                   mul_busy;
    logic [PROD_W-1:0]      mul_prod;

    logic                   any_nan, any_inf, any_zero, inf_zero, special;
    logic [WORD_W-1:0]      spec_word;
    logic                   spec_invalid;
    logic signed [XP_W-1:0] exp_sum;
    logic                   norm_right, norm_left;

    logic [WORD_W-1:0]      rnd_word;
    logic                   rnd_ovf, rnd_unf, rnd_inx;

    fp_mult_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_a (
        .word_i (op_a_q),
        .sign_o (sign_a),
        .class_o(cls_a),
        .sig_o  (sig_a),
        .exp_o  (exp_a)
    );

    fp_mult_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_b (
        .word_i (op_b_q),
        .sign_o (sign_b),
        .class_o(cls_b),
        .sig_o  (sig_b),
        .exp_o  (exp_b)
    );

    fp_mult_sigmul #(.SIG_W(SIG_W)) u_sigmul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (mul_start),
        .mcand_i (sig_a),
        .mplier_i(sig_b),
        .busy_o  (mul_busy),
        .prod_o  (mul_prod)
    );

    fp_mult_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XP_W(XP_W)) u_round (
        .sign_i  (sign_q),
        .exp_i   (exp_q),
        .mag_i   (prod_q),
        .sticky_i(sticky_q),
        .word_o  (rnd_word),
        .ovf_o   (rnd_ovf),
        .unf_o   (rnd_unf),
        .inx_o   (rnd_inx)
    );

    // special-operand resolution
    always_comb begin
        any_nan  = (cls_a == CL_NAN) || (cls_b == CL_NAN);
        any_inf  = (cls_a == CL_INF) || (cls_b == CL_INF);
        any_zero = (cls_a == CL_ZERO) || (cls_b == CL_ZERO);
        inf_zero = any_inf && any_zero;
        special  = any_nan || any_inf || any_zero;

        spec_invalid = 1'b0;
        if (any_nan) begin
            spec_word = QNAN_WORD;
        end else if (inf_zero) begin
            spec_word    = QNAN_WORD;
            spec_invalid = 1'b1;
        end else if (any_inf) begin
            spec_word = {sign_a ^ sign_b, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            spec_word = {sign_a ^ sign_b, {(WORD_W-1){1'b0}}};
        end

        exp_sum = $signed(XP_W'(exp_a)) + $signed(XP_W'(exp_b))
                - $signed(XP_W'(BIAS));
    end

    // normalization decisions
    always_comb begin
        norm_right = prod_q[PROD_W-1] || (exp_q < EXP_ONE);
        norm_left  = !prod_q[PROD_W-2] && (exp_q > EXP_ONE);
    end

    assign mul_start = (state_q == ST_CLASSIFY) && !special;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_CLASSIFY;
            ST_CLASSIFY:  state_d = special ? ST_DONE : ST_MULTIPLY;
            ST_MULTIPLY:  if (!mul_busy) state_d = ST_NORMALIZE;
            ST_NORMALIZE: if (!norm_right && !norm_left) state_d = ST_ROUND;
            ST_ROUND:     state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a_q   <= '0;
            op_b_q   <= '0;
            prod_q   <= '0;
            exp_q    <= '0;
            sticky_q <= 1'b0;
            sign_q   <= 1'b0;
            result_q <= '0;
            flags_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_a_q <= op_a_i;
                        op_b_q <= op_b_i;
                    end
                end
                ST_CLASSIFY: begin
                    sign_q   <= sign_a ^ sign_b;
                    exp_q    <= exp_sum;
                    sticky_q <= 1'b0;
                    if (special) begin
                        result_q <= spec_word;
                        flags_q  <= {spec_invalid, 3'b000};
                    end
                end
                ST_MULTIPLY: begin
                    if (!mul_busy)
                        prod_q <= mul_prod;
                end
                ST_NORMALIZE: begin
                    if (norm_right) begin
                        prod_q   <= prod_q >> 1;
                        sticky_q <= sticky_q | prod_q[0];
                        exp_q    <= exp_q + XP_W'(1);
                    end else if (norm_left) begin
                        prod_q <= prod_q << 1;
                        exp_q  <= exp_q - XP_W'(1);
                    end
                end
                ST_ROUND: begin
                    result_q <= rnd_word;
                    flags_q  <= {1'b0, rnd_ovf, rnd_unf, rnd_inx};
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_DONE);
    assign result_o    = result_q;
    assign invalid_o   = flags_q[3];
    assign overflow_o  = flags_q[2];
    assign underflow_o = flags_q[1];
    assign inexact_o   = flags_q[0];

endmodule

// File: rtl/fp_mult_unit_chk.sv
module fp_mult_unit_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic                  busy_o,
    input logic                  done_o,
    input logic [EXP_W+FRAC_W:0] result_o,
    input logic                  invalid_o,
    input logic                  overflow_o,
    input logic                  underflow_o,
    input logic                  inexact_o
);

    logic [EXP_W-1:0]  res_exp;
    logic [FRAC_W-1:0] res_frac;
    assign res_exp  = result_o[FRAC_W +: EXP_W];
    assign res_frac = result_o[FRAC_W-1:0];

    // R2: done lasts one cycle and ends the busy period
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    // R13: outputs frozen while idle
    a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(result_o) && $stable({invalid_o, overflow_o, underflow_o, inexact_o})));

    // R7: overflow returns infinity and is inexact
    a_r7_overflow_inf: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> ((&res_exp) && (res_frac == '0) && inexact_o));

    // R9: underflow only for tiny inexact results
    a_r9_underflow_tiny: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> ((res_exp == '0) && inexact_o));

    // R11: invalid gives canonical NaN
    a_r11_invalid_nan: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> ((&res_exp) && res_frac[FRAC_W-1] && !result_o[EXP_W+FRAC_W]));

    // R10: NaN results raise no arithmetic flags
    a_r10_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((&res_exp) && (res_frac != '0)) |-> (!overflow_o && !underflow_o && !inexact_o));

endmodule

bind fp_mult_unit fp_mult_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fp_mult_unit_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .invalid_o  (invalid_o),
    .overflow_o (overflow_o),
    .underflow_o(underflow_o),
    .inexact_o  (inexact_o)
);

// File: tb/fp_mult_unit_bench.sv
module fp_mult_unit_bench;

    localparam int EXP_W  = 3;
    localparam int FRAC_W = 3;
    localparam int W      = EXP_W + FRAC_W + 1;
    localparam int NV     = 31;

    // {a[7], b[7], expected result[7], flags {inv,ovf,unf,inx}[4], requirement[4]}
    localparam logic [28:0] VEC [NV] = '{
        {7'h18, 7'h18, 7'h18, 4'b0000, 4'd4},   // R4 1*1
        {7'h1C, 7'h1C, 7'h21, 4'b0000, 4'd4},   // R4 1.5*1.5 right shift
        {7'h19, 7'h19, 7'h1A, 4'b0001, 4'd5},   // R5 round down, sticky
        {7'h19, 7'h1C, 7'h1E, 4'b0001, 4'd5},   // R5 tie to even, up
        {7'h1A, 7'h1A, 7'h1C, 4'b0001, 4'd5},   // R5 tie to even, down
        {7'h1F, 7'h1F, 7'h26, 4'b0001, 4'd4},   // R4 shift right keeps sticky
        {7'h1E, 7'h19, 7'h20, 4'b0001, 4'd6},   // R6 carry renormalizes
        {7'h5C, 7'h1C, 7'h61, 4'b0000, 4'd3},   // R3 negative product
        {7'h5C, 7'h5C, 7'h21, 4'b0000, 4'd3},   // R3 neg*neg
        {7'h30, 7'h28, 7'h38, 4'b0101, 4'd7},   // R7 overflow +inf
        {7'h70, 7'h28, 7'h78, 4'b0101, 4'd7},   // R7 overflow -inf
        {7'h37, 7'h18, 7'h37, 4'b0000, 4'd7},   // R7 max finite stays
        {7'h2E, 7'h21, 7'h38, 4'b0101, 4'd6},   // R6 carry into overflow
        {7'h08, 7'h08, 7'h02, 4'b0000, 4'd9},   // R9 exact denormal
        {7'h08, 7'h0A, 7'h02, 4'b0011, 4'd9},   // R9 denormal tie
        {7'h08, 7'h01, 7'h00, 4'b0011, 4'd9},   // R9 flush to zero
        {7'h04, 7'h30, 7'h18, 4'b0000, 4'd8},   // R8 denormal in, left shift
        {7'h04, 7'h04, 7'h00, 4'b0011, 4'd8},   // R8 denorm*denorm
        {7'h07, 7'h19, 7'h08, 4'b0001, 4'd9},   // R9 rounds up to min normal
        {7'h3C, 7'h18, 7'h3C, 4'b0000, 4'd10},  // R10 NaN a
        {7'h7F, 7'h38, 7'h3C, 4'b0000, 4'd10},  // R10 NaN * inf
        {7'h18, 7'h3D, 7'h3C, 4'b0000, 4'd10},  // R10 NaN b
        {7'h38, 7'h00, 7'h3C, 4'b1000, 4'd11},  // R11 inf*0
        {7'h40, 7'h78, 7'h3C, 4'b1000, 4'd11},  // R11 -0*-inf
        {7'h38, 7'h60, 7'h78, 4'b0000, 4'd11},  // R11 inf*-2
        {7'h38, 7'h41, 7'h78, 4'b0000, 4'd11},  // R11 inf*-denorm
        {7'h78, 7'h78, 7'h38, 4'b0000, 4'd11},  // R11 -inf*-inf
        {7'h00, 7'h64, 7'h40, 4'b0000, 4'd12},  // R12 0*-3
        {7'h40, 7'h40, 7'h00, 4'b0000, 4'd12},  // R12 -0*-0
        {7'h00, 7'h01, 7'h00, 4'b0000, 4'd12},  // R12 0*denorm
        {7'h41, 7'h30, 7'h48, 4'b0000, 4'd8}    // R8 -denorm*8, three left shifts
    };

    logic         clk;
    logic         rst_n;
    logic         start_i;
    logic [W-1:0] op_a_i, op_b_i;
    logic         busy_o, done_o;
    logic [W-1:0] result_o;
    logic         invalid_o, overflow_o, underflow_o, inexact_o;

    int n_checks = 0;
    int n_fail   = 0;

    fp_mult_unit #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fp_mult_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_a_i     (op_a_i),
        .op_b_i     (op_b_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .result_o   (result_o),
        .invalid_o  (invalid_o),
        .overflow_o (overflow_o),
        .underflow_o(underflow_o),
        .inexact_o  (inexact_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // start at a falling edge, wait for done, sample at a falling edge
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          output logic [W-1:0] r, output logic [3:0] f);
        int waited;
        @(negedge clk);
        op_a_i  = a;
        op_b_i  = b;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited  = 0;
        while (!done_o && waited < 500) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 500)
            check(1'b0, "R2", "done never seen", 16'(done_o), 16'h1);
        r = result_o;
        f = {invalid_o, overflow_o, underflow_o, inexact_o};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog: actual still running expected finished");
        finish_run();
    end

    initial begin
        logic [W-1:0] r;
        logic [3:0]   f;
        logic [W-1:0] held;

        rst_n   = 1'b0;
        start_i = 1'b0;
        op_a_i  = '0;
        op_b_i  = '0;
        repeat (3) @(negedge clk);

        // R1: reset state
        check({busy_o, done_o, result_o, invalid_o, overflow_o, underflow_o, inexact_o} == '0,
              "R1", "outputs during reset",
              16'({busy_o, done_o, result_o, invalid_o, overflow_o, underflow_o, inexact_o}), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy_o, done_o, result_o} == '0, "R1", "outputs after reset release",
              16'({busy_o, done_o, result_o}), 16'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = VEC[i];
            run_op(v[28:22], v[21:15], r, f);
            n_checks++;
            if ({r, f} != v[14:4]) begin
                n_fail++;
                $display("FAIL R%0d vector %0d (%h*%h): actual %h/%b expected %h/%b",
                         v[3:0], i, v[28:22], v[21:15], r, f, v[14:8], v[7:4]);
            end
        end

        // R2: busy after accept, start while busy ignored, done single pulse
        @(negedge clk);
        op_a_i  = 7'h1C;
        op_b_i  = 7'h1C;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2", "busy after accepted start", 16'(busy_o), 16'h1);
        @(negedge clk);
        op_a_i  = 7'h30;
        op_b_i  = 7'h28;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        check({result_o, invalid_o, overflow_o, underflow_o, inexact_o} == {7'h21, 4'b0000},
              "R2", "start while busy ignored",
              16'({result_o, invalid_o, overflow_o, underflow_o, inexact_o}), 16'({7'h21, 4'b0000}));
        held = result_o;
        @(negedge clk);
        check({done_o, busy_o} == 2'b00, "R2", "done pulse ends busy",
              16'({done_o, busy_o}), 16'h0);

        // R13: result held while idle
        repeat (6) @(negedge clk);
        check(result_o == held && overflow_o == 1'b0, "R13", "result held while idle",
              16'(result_o), 16'(held));

        // R3: sign of overflowed infinity with negative b
        run_op(7'h30, 7'h68, r, f);
        check(r == 7'h78, "R3", "sign of -inf overflow", 16'(r), 16'h78);

        // R1: reset mid-operation clears outputs
        @(negedge clk);
        op_a_i  = 7'h1F;
        op_b_i  = 7'h1F;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({busy_o, done_o, result_o, invalid_o, overflow_o, underflow_o, inexact_o} == '0,
              "R1", "reset during operation",
              16'({busy_o, done_o, result_o, invalid_o, overflow_o, underflow_o, inexact_o}), 16'h0);
        rst_n = 1'b1;
        run_op(7'h1A, 7'h18, r, f);
        check({r, f} == {7'h1A, 4'b0000}, "R4", "operation after reset",
              16'({r, f}), 16'({7'h1A, 4'b0000}));

        finish_run();
    end

endmodule